// File: doc/BRIEF.md
# Dual-Rate SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. A transfer sequencer raises `run` for as long as it wants clock cycles; while `run` is high the block produces a continuous stream of serial clock cycles, and it returns the clock to its idle level as soon as `run` drops. Each half of a serial clock cycle lasts a whole number of system clocks, set by a divider value.

Two divider values are supplied. When variable-rate operation is off, every serial clock cycle uses the primary divider. When it is on, a pattern word picks the divider for each serial clock cycle: successive pattern bits govern successive cycles, starting from bit 0 at the beginning of each run and wrapping round after the last bit. The choice is made only when a serial clock cycle begins, so a half-period is never stretched or cut short.

The serial clock rests at a programmable polarity. Alongside it, the block issues two single-cycle strobes for the shift logic: one on the edge that moves the clock away from its resting level, one on the edge that brings it back.

Top module: `spi_dualrate_sclk`

## Requirements
- R1: After reset, `sclk` equals `cpol` and both `lead_stb` and `trail_stb` are low.
- R2: Each half of a serial clock cycle lasts exactly (divider + 1) system clock cycles. The first leading edge appears (divider + 1) cycles after the clock edge that first samples `run` high, so a divider of 0 gives a half-period of one system clock.
- R3: With `var_en` low, every serial clock cycle uses `div_a`, whatever the pattern holds.
- R4: With `var_en` high, bit k of `pattern` selects the divider for serial clock cycle k of the run: a 0 bit selects `div_a` and a 1 bit selects `div_b`.
- R5: After the cycle governed by the last pattern bit (bit PAT_W-1), the next serial clock cycle is governed by bit 0 again.
- R6: The divider for a serial clock cycle is sampled at the edge where that cycle begins. A change to `div_a`, `div_b`, `var_en` or `pattern` during a cycle affects only later cycles.
- R7: `lead_stb` is high for exactly one system clock, in the cycle in which `sclk` first differs from `cpol`. `trail_stb` is high for one cycle in the cycle in which `sclk` returns to `cpol`. The two strobes are never high together.
- R8: From the cycle after an edge that samples `run` low, `sclk` equals `cpol` and no strobe is issued. The next run starts again with pattern bit 0.
- R9: The resting level of `sclk` follows `cpol`. With `cpol` = 1, the clock idles high and the leading edge drives it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Clock enable from the transfer sequencer |
| cpol | input | 1 | Resting level of the serial clock |
| var_en | input | 1 | Enables per-cycle choice between the two dividers |
| div_a | input | DIV_W | Primary divider (half-period = div_a + 1 system clocks) |
| div_b | input | DIV_W | Alternate divider (half-period = div_b + 1 system clocks) |
| pattern | input | PAT_W | Per-cycle divider choice, bit k for serial cycle k |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the edge that leaves the resting level |
| trail_stb | output | 1 | One-cycle strobe on the edge that returns to the resting level |

## Verification
The hardest situation to reach from the ports is the pattern wrap: a run has to last more than PAT_W full serial clock cycles before bit 0 governs a cycle for the second time. The stimulus uses dividers of 0 and 1 with a pattern whose first and last bits are set, so a long run stays short in system clocks and the wrap shows up as a change in the gap between edges. A second hard case is a divider change in the middle of a half-period. The bench rewrites `div_a` two system clocks into the first half of a cycle and expects the old half-period to finish before the new one applies.

// File: rtl/spi_drclk_pkg.sv
package spi_drclk_pkg;

   // Which half of the serial clock cycle is in progress.
   typedef enum logic {
      PH_LEAD  = 1'b0,   // clock at resting level, waiting for the leading edge
      PH_TRAIL = 1'b1    // clock away from rest, waiting for the trailing edge
   } half_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/drclk_rate_sel.sv
module drclk_rate_sel
   import spi_drclk_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int PAT_W       = 32,
   parameter bit VAR_SUPPORT = 1'b1,
   localparam int IDX_W      = idx_width(PAT_W)
) (
   input  logic             var_en,
   input  logic [DIV_W-1:0] div_a,
   input  logic [DIV_W-1:0] div_b,
   input  logic [PAT_W-1:0] pattern,
   input  logic [IDX_W-1:0] idx_nxt,
   output logic [DIV_W-1:0] div_sel
);

   generate
      if (VAR_SUPPORT) begin : g_var
         logic pick_alt;
         always_comb begin
            pick_alt = var_en & pattern[idx_nxt];
            div_sel  = pick_alt ? div_b : div_a;
         end
      end else begin : g_fixed
         logic             unused_ok;
         assign unused_ok = var_en ^ (^div_b) ^ (^pattern) ^ (^idx_nxt);
         assign div_sel   = div_a;
      end
   endgenerate

endmodule

// File: rtl/drclk_half_timer.sv
module drclk_half_timer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             active,
   input  logic             load_en,
   input  logic [DIV_W-1:0] load_val,
   output logic             expire
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim_q;

   assign expire = active && (cnt_q == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (load_en) begin
         cnt_q <= '0;
         lim_q <= load_val;
      end else if (expire) begin
         cnt_q <= '0;
      end else if (active) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2
   cnt_le_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt_q <= lim_q));

   // R6
   lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load_en) |=> $stable(lim_q));

endmodule

// File: rtl/drclk_phase_seq.sv
module drclk_phase_seq
   import spi_drclk_pkg::*;
#(
   parameter int PAT_W  = 32,
   localparam int IDX_W = idx_width(PAT_W),
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_W - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             expire,
   output logic             active,
   output half_e            phase,
   output logic [IDX_W-1:0] idx_nxt,
   output logic             load_en,
   output logic             lead_stb,
   output logic             trail_stb
);

   logic [IDX_W-1:0] idx_q;

   always_comb begin
      if (!active)                idx_nxt = '0;
      else if (idx_q == LAST_IDX) idx_nxt = '0;
      else                        idx_nxt = idx_q + 1'b1;
      load_en = run && (!active || (expire && phase == PH_TRAIL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         phase     <= PH_LEAD;
         idx_q     <= '0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (!run) begin
         active    <= 1'b0;
         phase     <= PH_LEAD;
         idx_q     <= '0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (!active) begin
         active    <= 1'b1;
         phase     <= PH_LEAD;
         idx_q     <= '0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else begin
         lead_stb  <= expire && (phase == PH_LEAD);
         trail_stb <= expire && (phase == PH_TRAIL);
         if (expire) begin
            phase <= (phase == PH_LEAD) ? PH_TRAIL : PH_LEAD;
            if (phase == PH_TRAIL) idx_q <= idx_nxt;
         end
      end
   end

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));

   // R7
   lead_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |=> !lead_stb);

   // R8
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!lead_stb && !trail_stb && phase == PH_LEAD));

   // R5
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX);

endmodule

// File: rtl/spi_dualrate_sclk.sv
module spi_dualrate_sclk
   import spi_drclk_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int PAT_W       = 32,
   parameter bit VAR_SUPPORT = 1'b1,
   localparam int IDX_W      = idx_width(PAT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             cpol,
   input  logic             var_en,
   input  logic [DIV_W-1:0] div_a,
   input  logic [DIV_W-1:0] div_b,
   input  logic [PAT_W-1:0] pattern,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb
);

   generate
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
         $error("spi_dualrate_sclk: DIV_W must lie in 1..32");
      end
      if (PAT_W < 1 || PAT_W > 256) begin : g_bad_pat
         $error("spi_dualrate_sclk: PAT_W must lie in 1..256");
      end
   endgenerate

   logic             active;
   half_e            phase;
   logic [IDX_W-1:0] idx_nxt;
   logic             load_en;
   logic             expire;
   logic [DIV_W-1:0] div_sel;

   drclk_rate_sel #(
      .DIV_W      (DIV_W),
      .PAT_W      (PAT_W),
      .VAR_SUPPORT(VAR_SUPPORT)
   ) u_rate_sel (
      .var_en (var_en),
      .div_a  (div_a),
      .div_b  (div_b),
      .pattern(pattern),
      .idx_nxt(idx_nxt),
      .div_sel(div_sel)
   );

   drclk_half_timer #(
      .DIV_W(DIV_W)
   ) u_half_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .active  (active),
      .load_en (load_en),
      .load_val(div_sel),
      .expire  (expire)
   );

   drclk_phase_seq #(
      .PAT_W(PAT_W)
   ) u_phase_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .expire   (expire),
      .active   (active),
      .phase    (phase),
      .idx_nxt  (idx_nxt),
      .load_en  (load_en),
      .lead_stb (lead_stb),
      .trail_stb(trail_stb)
   );

   assign sclk = cpol ^ (phase == PH_TRAIL);

   // R9
   lead_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |-> (sclk != cpol));

   // R9
   trail_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trail_stb |-> (sclk == cpol));

endmodule

// File: tb/spi_dualrate_sclk_bench.sv
module spi_dualrate_sclk_bench;

   localparam int DW = 16;
   localparam int PW = 32;

   typedef struct {
      int    cyc;
      bit    lead;
      bit    lvl;
      string req;
   } ev_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          cpol = 1'b0;
   logic          var_en = 1'b0;
   logic [DW-1:0] div_a = '0;
   logic [DW-1:0] div_b = '0;
   logic [PW-1:0] pattern = '0;
   logic          sclk;
   logic          lead_stb;
   logic          trail_stb;

   int  cyc = 0;
   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   ev_t expq[$];

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   spi_dualrate_sclk #(.DIV_W(DW), .PAT_W(PW)) u_spi_dualrate_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .cpol     (cpol),
      .var_en   (var_en),
      .div_a    (div_a),
      .div_b    (div_b),
      .pattern  (pattern),
      .sclk     (sclk),
      .lead_stb (lead_stb),
      .trail_stb(trail_stb)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   // Monitor: pop and compare every strobe the design issues.
   always @(negedge clk) begin : mon
      ev_t e;
      if (rst_n && !done) begin
         if (lead_stb && trail_stb) check(1'b0, "R7 both strobes", 1, 0);
         if (lead_stb || trail_stb) begin
            if (expq.size() == 0) begin
               check(1'b0, "R8 unexpected strobe", cyc, -1);
            end else begin
               e = expq.pop_front();
               check(cyc == e.cyc, {e.req, " edge cycle"}, cyc, e.cyc);
               check(lead_stb == e.lead, {e.req, " R7 strobe kind"}, int'(lead_stb), int'(e.lead));
               check(sclk == e.lvl, {e.req, " R9 sclk level"}, int'(sclk), int'(e.lvl));
            end
         end
      end
   end

   task automatic push(input int t, input bit lead, input bit lvl, input string req);
      ev_t e;
      e.cyc = t; e.lead = lead; e.lvl = lvl; e.req = req;
      expq.push_back(e);
   endtask

   task automatic idle_check(input bit pol, input string req);
      @(negedge clk);
      check(expq.size() == 0, {req, " missing edges"}, expq.size(), 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(sclk == pol && !lead_stb && !trail_stb, {req, " R8 idle"}, int'(sclk), int'(pol));
      end
   endtask

   // Driver: start a run, push expected edges, stop after n cycles or at stop.
   task automatic burst(input int a, input int b, input bit ve, input logic [PW-1:0] pat,
                        input bit pol, input int n, input int stop, input string req);
      int e0, t, d, tend;
      @(negedge clk);
      cpol = pol;
      @(negedge clk);
      check(sclk == pol, "R9 idle level", int'(sclk), int'(pol));
      div_a = DW'(a); div_b = DW'(b); var_en = ve; pattern = pat; run = 1'b1;
      e0 = cyc + 1;
      t  = e0;
      for (int k = 0; k < n; k++) begin
         d = (ve && pat[k % PW]) ? b : a;
         t += d + 1;
         if (stop == 0 || t <= e0 + stop) push(t, 1'b1, ~pol, req);
         t += d + 1;
         if (stop == 0 || t <= e0 + stop) push(t, 1'b0, pol, req);
      end
      tend = (stop == 0) ? t : e0 + stop;
      while (cyc < tend) @(negedge clk);
      run = 1'b0;
      idle_check(pol, req);
   endtask

   initial begin : drive
      int e0;
      // R1: reset state
      cpol = 1'b0;
      repeat (3) @(negedge clk);
      check(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 reset", int'(sclk), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 after reset", int'(sclk), 0);

      // R3: variable mode off ignores the pattern; R2 timing
      burst(2, 9, 1'b0, 32'hFFFF_FFFF, 1'b0, 4, 0, "R3");
      // R4: pattern bits 1 and 2 pick div_b
      burst(1, 4, 1'b1, 32'h0000_0006, 1'b0, 5, 0, "R4");
      // R2: smallest divider gives one-cycle halves
      burst(0, 0, 1'b1, 32'h0000_0005, 1'b0, 3, 0, "R2 min");
      // R2: wide divider value
      burst(300, 0, 1'b0, 32'h0, 1'b0, 1, 0, "R2 wide");
      // R5: run past the pattern end so bit 0 governs again
      burst(0, 1, 1'b1, 32'h8000_0001, 1'b0, 34, 0, "R5");
      // R9: resting level high
      burst(1, 3, 1'b1, 32'h0000_00A5, 1'b1, 4, 0, "R9");
      // R8: stop in the middle of the first cycle's trailing half
      burst(2, 5, 1'b1, 32'h0000_0001, 1'b0, 4, 9, "R8 stop");
      // R8: restart begins from pattern bit 0 again
      burst(2, 5, 1'b1, 32'h0000_0001, 1'b0, 2, 0, "R8 restart");

      // R6: change div_a during the first half of cycle 0
      @(negedge clk);
      cpol = 1'b0; div_a = DW'(3); var_en = 1'b0; run = 1'b1;
      e0 = cyc + 1;
      push(e0 + 4,  1'b1, 1'b1, "R6");
      push(e0 + 8,  1'b0, 1'b0, "R6");
      push(e0 + 10, 1'b1, 1'b1, "R6");
      push(e0 + 12, 1'b0, 1'b0, "R6");
      while (cyc < e0 + 2) @(negedge clk);
      div_a = DW'(1);
      while (cyc < e0 + 12) @(negedge clk);
      run = 1'b0;
      idle_check(1'b0, "R6");

      finish_run();
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
      finish_run();
   end

endmodule